// File: doc/BRIEF.md
# Parallel Bit Extract/Deposit Unit

This block moves bits between a data word and the positions picked out by a mask word. In **extract** mode it gathers every data bit whose mask bit is set and packs those bits together at the low end of the result. In **deposit** mode it does the reverse. It takes the lowest-order data bits in turn and places them, one by one, at the set mask positions. The mask is walked from the least significant bit upward in both modes, and a running count of set mask bits picks the packed position.

A request is made of an opcode bit, a data word, a mask word and a record flag, presented with a valid strobe. The result is registered and appears one cycle later with its own valid strobe. When the record flag is set, a three-bit condition code reports whether the signed result is negative, positive or zero.

The control is a two-state machine. **ST_IDLE** means no response is presented. **ST_RESP** means a registered response is on the outputs. The transitions are:
- **T_ACCEPT**: from ST_IDLE to ST_RESP on a request.
- **T_STREAM**: from ST_RESP to ST_RESP on a back-to-back request.
- **T_DRAIN**: from ST_RESP to ST_IDLE when no request arrives.
- **T_WAIT**: from ST_IDLE to ST_IDLE with no request.

Top module: `pbx_unit`

## Requirements
- R1: With `req_op`=0 (extract), result bit k (bit 0 = LSB) is the data bit at the position of the k-th set mask bit, counting set bits from the LSB starting at k=0.
- R2: With `req_op`=1 (deposit), at the position of the k-th set mask bit (counted from the LSB, k from 0) the result holds data bit k.
- R3: Result bits not written by the scan are zero: in extract, every bit at or above the mask's population count; in deposit, every bit where the mask is clear.
- R4: An all-zero mask yields a zero result in both modes.
- R5: An all-ones mask yields the data word unchanged in both modes.
- R6: With `req_rec`=1, `rsp_cc` is one-hot with bit 2 = result negative (bit 63 set), bit 1 = result positive and nonzero, and bit 0 = result zero.
- R7: With `req_rec`=0, `rsp_cc` is 3'b000.
- R8: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, including back-to-back requests.
- R9: A synchronous reset clears `rsp_valid`, `rsp_result` and `rsp_cc` to zero.
- R10: While no request is accepted, `rsp_result` and `rsp_cc` keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_op | input | 1 | 0 = extract, 1 = deposit |
| req_data | input | 64 | Data word |
| req_mask | input | 64 | Mask word |
| req_rec | input | 1 | Record flag: produce a condition code |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_result | output | 64 | Registered result |
| rsp_cc | output | 3 | {negative, positive, zero} for the result when recorded |

## Verification
If the state register is wrong, `rsp_valid` shows it in the first cycle after the request: the strobe is missing, is repeated, or is held past the last request. A fault in the running set-bit count affects data bits only from the first set mask bit it miscounts onward. So masks with sparse, dense, edge-only and alternating patterns are used to expose such a fault in the very response that carries it. If the condition code is wrong, the same cycle shows either a code that disagrees with the sign of the result or a code that is not one-hot.

// File: rtl/pbx_pkg.sv
package pbx_pkg;

    typedef enum logic {
        OP_EXTRACT = 1'b0,
        OP_DEPOSIT = 1'b1
    } pbx_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } pbx_state_e;

    typedef struct packed {
        logic neg;
        logic pos;
        logic zero;
    } pbx_cc_t;

endpackage

// File: rtl/pbx_extract.sv
module pbx_extract #(
    parameter int W = 64
) (
    input  logic [W-1:0] data,
    input  logic [W-1:0] mask,
    output logic [W-1:0] result
);
    localparam int IW = $clog2(W);
    localparam int KW = IW + 1;

    logic [KW-1:0] k;

    // Walk the mask from the LSB; each set bit takes the next packed slot.
    always_comb begin
        result = '0;
        k      = '0;
        for (int m = 0; m < W; m++) begin
            if (mask[m]) begin
                result[k[IW-1:0]] = data[m];
                k = k + KW'(1);
            end
        end
    end

endmodule

// File: rtl/pbx_deposit.sv
module pbx_deposit #(
    parameter int W = 64
) (
    input  logic [W-1:0] data,
    input  logic [W-1:0] mask,
    output logic [W-1:0] result
);
    localparam int IW = $clog2(W);
    localparam int KW = IW + 1;

    logic [KW-1:0] k;

    // Each set mask bit consumes the next low-order data bit.
    always_comb begin
        result = '0;
        k      = '0;
        for (int m = 0; m < W; m++) begin
            if (mask[m]) begin
                result[m] = data[k[IW-1:0]];
                k = k + KW'(1);
            end
        end
    end

endmodule

// File: rtl/pbx_cc.sv
module pbx_cc
    import pbx_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] value,
    input  logic         rec,
    output pbx_cc_t      cc
);
    logic is_zero;
    logic is_neg;

    assign is_zero = (value == '0);
    assign is_neg  = value[W-1];

    always_comb begin
        cc      = '0;
        cc.neg  = rec & is_neg;
        cc.zero = rec & is_zero;
        cc.pos  = rec & ~is_neg & ~is_zero;
    end

endmodule

// File: rtl/pbx_unit.sv
module pbx_unit
    import pbx_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    input  logic         req_op,
    input  logic [W-1:0] req_data,
    input  logic [W-1:0] req_mask,
    input  logic         req_rec,
    output logic         rsp_valid,
    output logic [W-1:0] rsp_result,
    output logic [2:0]   rsp_cc
);
    localparam int CCW = $bits(pbx_cc_t);

    pbx_state_e state_q, state_d;

    logic [W-1:0] ext_res;
    logic [W-1:0] dep_res;
    logic [W-1:0] sel_res;
    pbx_cc_t      sel_cc;

    pbx_extract #(.W(W)) u_ext (
        .data   (req_data),
        .mask   (req_mask),
        .result (ext_res)
    );

    pbx_deposit #(.W(W)) u_dep (
        .data   (req_data),
        .mask   (req_mask),
        .result (dep_res)
    );

    assign sel_res = (pbx_op_e'(req_op) == OP_DEPOSIT) ? dep_res : ext_res;

    pbx_cc #(.W(W)) u_cc (
        .value (sel_res),
        .rec   (req_rec),
        .cc    (sel_cc)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;  // T_ACCEPT / T_WAIT
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;  // T_STREAM / T_DRAIN
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Output registers: loaded only on an accepted request
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_result <= '0;
            rsp_cc     <= '0;
        end else if (req_valid) begin
            rsp_result <= sel_res;
            rsp_cc     <= CCW'(sel_cc);
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

endmodule

// File: rtl/pbx_unit_chk.sv
module pbx_unit_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         req_valid,
    input logic         req_op,
    input logic [W-1:0] req_data,
    input logic [W-1:0] req_mask,
    input logic         req_rec,
    input logic         rsp_valid,
    input logic [W-1:0] rsp_result,
    input logic [2:0]   rsp_cc
);

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(rsp_result) && $stable(rsp_cc)));

    a_r6_cc_onehot: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $onehot0(rsp_cc));

    a_r6_zero_flag: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_cc[0]) |-> (rsp_result == '0));

    a_r7_no_record: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_rec) |=> (rsp_cc == 3'b000));

    a_r4_zero_mask: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mask == '0) |=> (rsp_result == '0));

    a_r5_full_mask: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (&req_mask)) |=> (rsp_result == $past(req_data)));

    a_r3_deposit_clear: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op) |=> ((rsp_result & ~$past(req_mask)) == '0));

endmodule

bind pbx_unit pbx_unit_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_data   (req_data),
    .req_mask   (req_mask),
    .req_rec    (req_rec),
    .rsp_valid  (rsp_valid),
    .rsp_result (rsp_result),
    .rsp_cc     (rsp_cc)
);

// File: tb/pbx_unit_tb.sv
module pbx_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_op;
    logic [63:0] req_data;
    logic [63:0] req_mask;
    logic        req_rec;
    logic        rsp_valid;
    logic [63:0] rsp_result;
    logic [2:0]  rsp_cc;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #2 clk = ~clk;   // 250 MHz

    pbx_unit u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .req_mask(req_mask), .req_rec(req_rec),
        .rsp_valid(rsp_valid), .rsp_result(rsp_result), .rsp_cc(rsp_cc)
    );

    typedef struct packed {
        logic        op;
        logic [63:0] data;
        logic [63:0] mask;
        logic        rec;
        logic [63:0] exp;
        logic [2:0]  cc;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 64'h0000_0000_0000_00F0, 64'h0000_0000_0000_00F0, 1'b1, 64'h0000_0000_0000_000F, 3'b010},
        '{1'b0, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_0000_0000_0000, 1'b1, 64'h0000_0000_0000_1234, 3'b010},
        '{1'b0, 64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, 64'h0000_0000_FFFF_FFFF, 3'b010},
        '{1'b0, 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1, 64'h0000_0000_0000_0000, 3'b001},
        '{1'b0, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 1'b1, 64'h0000_0000_0000_0003, 3'b010},
        '{1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 3'b000},
        '{1'b1, 64'h0000_0000_0000_1234, 64'hFFFF_0000_0000_0000, 1'b1, 64'h1234_0000_0000_0000, 3'b010},
        '{1'b1, 64'h0000_0000_FFFF_FFFF, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, 64'hAAAA_AAAA_AAAA_AAAA, 3'b100},
        '{1'b1, 64'h0000_0000_0000_0003, 64'h8000_0000_0000_0001, 1'b1, 64'h8000_0000_0000_0001, 3'b100},
        '{1'b1, 64'h0000_0000_0000_0002, 64'h8000_0000_0000_0001, 1'b1, 64'h8000_0000_0000_0000, 3'b100},
        '{1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 1'b1, 64'h0000_0000_0000_0000, 3'b001},
        '{1'b1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 64'h8000_0000_0000_0000, 3'b000}
    };

    // Reference: peel the lowest set mask bit each round.
    function automatic logic [63:0] ref_extract(logic [63:0] d, logic [63:0] m);
        logic [63:0] r = '0;
        logic [63:0] low;
        int k = 0;
        while (m != 0) begin
            low = m & (~m + 64'd1);
            if ((d & low) != 0) r = r | (64'd1 << k);
            k++;
            m = m & (m - 64'd1);
        end
        return r;
    endfunction

    function automatic logic [63:0] ref_deposit(logic [63:0] d, logic [63:0] m);
        logic [63:0] r = '0;
        logic [63:0] low;
        while (m != 0) begin
            low = m & (~m + 64'd1);
            if (d[0]) r = r | low;
            d = d >> 1;
            m = m & (m - 64'd1);
        end
        return r;
    endfunction

    function automatic logic [2:0] ref_cc(logic [63:0] v, logic rec);
        if (!rec) return 3'b000;
        if (v == 0) return 3'b001;
        if (v[63]) return 3'b100;
        return 3'b010;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic next_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 7);
        lfsr = lfsr ^ (lfsr << 17);
    endtask

    // Drive one request at a falling edge, sample its response a cycle later.
    task automatic run_one(logic op, logic [63:0] d, logic [63:0] m, logic rec);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_data = d; req_mask = m; req_rec = rec;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #400000;
        n_fail++; n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_op = 1'b0;
        req_data = '0; req_mask = '0; req_rec = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check("R9 valid after reset", 64'(rsp_valid), 64'd0);
        check("R9 result after reset", rsp_result, 64'd0);
        check("R9 cc after reset", 64'(rsp_cc), 64'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            run_one(VECS[i].op, VECS[i].data, VECS[i].mask, VECS[i].rec);
            check("R8 valid", 64'(rsp_valid), 64'd1);
            check(VECS[i].op ? "R2 deposit vec" : "R1 extract vec", rsp_result, VECS[i].exp);
            check(VECS[i].rec ? "R6 cc vec" : "R7 cc vec", 64'(rsp_cc), 64'(VECS[i].cc));
        end

        // Random against reference models
        for (int i = 0; i < 300; i++) begin
            logic [63:0] d, m, e;
            logic op, rec;
            next_rand(); d = lfsr;
            next_rand(); m = (i % 3 == 0) ? (lfsr & (lfsr >> 5)) : lfsr;
            op = i[0]; rec = i[1];
            e = op ? ref_deposit(d, m) : ref_extract(d, m);
            run_one(op, d, m, rec);
            check(op ? "R2 deposit rand" : "R1 extract rand", rsp_result, e);
            if (op) check("R3 deposit unwritten", rsp_result & ~m, 64'd0);
            else    check("R3 extract upper", rsp_result >> $countones(m), 64'd0);
            check(rec ? "R6 cc rand" : "R7 cc rand", 64'(rsp_cc), 64'(ref_cc(e, rec)));
        end

        // R4 / R5 both modes
        for (int op = 0; op < 2; op++) begin
            run_one(op[0], 64'hDEAD_BEEF_0123_4567, 64'd0, 1'b1);
            check("R4 zero mask", rsp_result, 64'd0);
            run_one(op[0], 64'hDEAD_BEEF_0123_4567, '1, 1'b1);
            check("R5 ones mask", rsp_result, 64'hDEAD_BEEF_0123_4567);
        end

        // R10 hold and R8 drain
        @(negedge clk);
        check("R8 valid drains", 64'(rsp_valid), 64'd0);
        req_data = 64'h1; req_mask = '1; req_rec = 1'b1;   // no strobe
        @(negedge clk);
        check("R10 result held", rsp_result, 64'hDEAD_BEEF_0123_4567);
        check("R10 cc held", 64'(rsp_cc), 64'b100);

        // R8 back-to-back
        @(negedge clk);
        req_valid = 1'b1; req_op = 1'b0; req_data = 64'hF0; req_mask = 64'hF0; req_rec = 1'b0;
        @(negedge clk);
        check("R8 b2b first valid", 64'(rsp_valid), 64'd1);
        check("R8 b2b first result", rsp_result, 64'hF);
        req_op = 1'b1; req_data = 64'h5; req_mask = 64'hF00;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 b2b second valid", 64'(rsp_valid), 64'd1);
        check("R8 b2b second result", rsp_result, 64'h500);

        // R9 reset mid-stream
        @(negedge clk);
        req_valid = 1'b1; req_data = '1; req_mask = '1; req_rec = 1'b1; rst = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; rst = 1'b0;
        check("R9 valid cleared", 64'(rsp_valid), 64'd0);
        check("R9 result cleared", rsp_result, 64'd0);
        check("R9 cc cleared", 64'(rsp_cc), 64'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule